// File: doc/BRIEF.md
# Tagged Byte/Word FIFO Access Port

This block connects a 32-bit register bus to two byte queues: a transmit queue that a serial engine drains and a receive queue that the serial engine fills. Every queue entry is nine bits wide, holding a data byte and a command tag in bit 8. The tag marks the byte that opens a frame. Software reaches the queues through three access registers: a plain data word, a frame-start byte and a frame-start word. A fourth address holds the status word.

A write to a word register splits the word into four bytes and pushes them one per clock, least significant byte first. A write to the byte register pushes one byte. The frame-start registers set the tag on the first pushed byte only. A read pops one or four bytes and reassembles them. Before a word access starts, the block checks for four free transmit entries or four stored receive bytes. An access that cannot complete moves no data and raises a sticky overflow or underflow flag. Every access updates the matching transfer-size field. Each access ends with a one-cycle `bus_ack`, and the read data is valid in that cycle.

A controller state machine runs every access. `IDLE` decodes a request pulse. `IDLE→PUSH` fires on a write that has room, `IDLE→POP` fires on a read that has data, and `IDLE→DONE` fires on a status access or a refused access. `PUSH→DONE` and `POP→DONE` fire after the last byte. `DONE→IDLE` always follows. Requests are accepted only in `IDLE`.

Top module: `tagged_fifo_port`

## Requirements
- R1: A write to address 0 (data word) pushes four transmit entries in the order bits [7:0], [15:8], [23:16], [31:24], each with tag bit 8 = 0.
- R2: A write to address 1 (frame-start byte) pushes one transmit entry holding bits [7:0] with tag bit 8 = 1.
- R3: A write to address 2 (frame-start word) pushes four entries least significant byte first, with tag = 1 on the first entry and 0 on the other three.
- R4: A word write when fewer than four transmit entries are free sets overflow (status bit 2) and pushes nothing.
- R5: A byte write when the transmit queue is full sets overflow and pushes nothing. Status bit 4 reports a full transmit queue.
- R6: A word read when fewer than four receive bytes are stored sets underflow (status bit 3), pops nothing, and leaves the stored bytes in place.
- R7: A byte read from address 1 when the receive queue is empty sets underflow.
- R8: A word read (address 0 or 2) returns the first popped byte in [7:0] and the last in [31:24]. A byte read returns the byte zero-extended.
- R9: Status bit 7 holds the tag of the byte popped by the last read that completed, or of the first byte of a popped word.
- R10: Every data write sets status bit 0 (transmit size) to 1 for a word and 0 for a byte. Every data read sets status bit 1 (receive size) the same way. This holds for refused accesses too.
- R11: Overflow and underflow are sticky. Writing address 3 with bit 2 or bit 3 set clears the matching flag, and nothing else clears it.
- R12: After reset, the read data is 0, all flags are 0, status bit 5 (transmit empty) and status bit 8 (receive empty) are 1, and status bit 6 (receive full) is 0.
- R13: Every access ends with `bus_ack` high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_req | input | 1 | One-cycle access request, accepted in IDLE |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | 0 data word, 1 frame byte, 2 frame word, 3 status |
| bus_wdata | input | 32 | Write data |
| bus_ack | output | 1 | Access complete, one cycle |
| bus_rdata | output | 32 | Read data, valid with bus_ack |
| tx_pop | input | 1 | Serial side takes the head of the transmit queue |
| tx_dout | output | 9 | Transmit head: tag in bit 8, byte in [7:0] |
| tx_empty | output | 1 | Transmit queue empty |
| rx_push | input | 1 | Serial side stores a received entry |
| rx_din | input | 9 | Received entry: tag in bit 8, byte in [7:0] |
| rx_full | output | 1 | Receive queue full |

## Verification
The bench goes after the capacity edges. It fills the transmit queue to exactly three free entries before a word write, and to exactly full before a byte write. A design that pushed a partial word, or that tested for one free entry instead of four, shows extra or missing entries when the queue is drained. On the receive side, three stored bytes must survive a refused word read and then come out by byte reads in order. A design that popped before checking would lose them. The bench also checks that the tag appears only on the first byte of a frame word, that the word assembly is in the right byte order, and that the flags stay set until software clears them.

// File: rtl/tfp_pkg.sv
`timescale 1ns/1ps
package tfp_pkg;
    localparam logic [1:0] A_DWORD  = 2'd0;
    localparam logic [1:0] A_FBYTE  = 2'd1;
    localparam logic [1:0] A_FWORD  = 2'd2;
    localparam logic [1:0] A_STATUS = 2'd3;

    localparam int ENTRY_W = 9;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PUSH,
        ST_POP,
        ST_DONE
    } ctl_state_t;
endpackage

// File: rtl/tfp_fifo.sv
`timescale 1ns/1ps
module tfp_fifo #(
    parameter int W     = 9,
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [W-1:0]               din,
    input  logic                       pop,
    output logic [W-1:0]               dout,
    output logic [$clog2(DEPTH):0]     count,
    output logic                       full,
    output logic                       empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          push_ok, pop_ok;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign dout    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wr_ptr] <= din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) begin
                wr_ptr <= wr_ptr + 1'b1;
            end
            if (pop_ok) begin
                rd_ptr <= rd_ptr + 1'b1;
            end
            unique case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/tfp_ctl.sv
`timescale 1ns/1ps
module tfp_ctl
    import tfp_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req,
    input  logic                   we,
    input  logic [1:0]             addr,
    input  logic [31:0]            wdata,
    output logic                   ack,
    output logic [31:0]            rdata,
    input  logic [$clog2(DEPTH):0] tx_count,
    input  logic                   tx_full,
    input  logic                   tx_empty,
    output logic                   tx_push,
    output logic [ENTRY_W-1:0]     tx_din,
    input  logic [$clog2(DEPTH):0] rx_count,
    input  logic                   rx_full,
    input  logic                   rx_empty,
    input  logic [ENTRY_W-1:0]     rx_head,
    output logic                   rx_pop,
    output logic                   ovf,
    output logic                   unf
);
    localparam int CW = $clog2(DEPTH) + 1;

    ctl_state_t    state, nxt;
    logic [31:0]   shreg;
    logic [31:0]   asm;
    logic [2:0]    left;
    logic          tag_pend;
    logic          first_rd;
    logic          word_op;
    logic          stat_sel;
    logic          size_tx, size_rx;
    logic          tag_seen;

    logic          is_stat, acc_word, acc_frame, tx_ok, rx_ok;
    logic [CW-1:0] need, free;
    logic [8:0]    status;

    // request decode
    always_comb begin
        is_stat   = (addr == A_STATUS);
        acc_word  = (addr != A_FBYTE);
        acc_frame = (addr != A_DWORD);
        need      = acc_word ? CW'(4) : CW'(1);
        free      = CW'(DEPTH) - tx_count;
        tx_ok     = (free >= need);
        rx_ok     = (rx_count >= need);
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (req) begin
                    if (is_stat)  nxt = ST_DONE;
                    else if (we)  nxt = tx_ok ? ST_PUSH : ST_DONE;
                    else          nxt = rx_ok ? ST_POP  : ST_DONE;
                end
            end
            ST_PUSH: if (left == 3'd1) nxt = ST_DONE;
            ST_POP:  if (left == 3'd1) nxt = ST_DONE;
            ST_DONE: nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // outputs
    always_comb begin
        status  = {rx_empty, tag_seen, rx_full, tx_empty, tx_full,
                   unf, ovf, size_rx, size_tx};
        tx_push = (state == ST_PUSH);
        tx_din  = {tag_pend, shreg[7:0]};
        rx_pop  = (state == ST_POP);
        ack     = (state == ST_DONE);
        rdata   = stat_sel ? {23'd0, status} : asm;
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg    <= '0;
            asm      <= '0;
            left     <= '0;
            tag_pend <= 1'b0;
            first_rd <= 1'b0;
            word_op  <= 1'b0;
            stat_sel <= 1'b0;
            size_tx  <= 1'b0;
            size_rx  <= 1'b0;
            tag_seen <= 1'b0;
            ovf      <= 1'b0;
            unf      <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (req) begin
                        stat_sel <= is_stat;
                        word_op  <= acc_word;
                        if (is_stat) begin
                            if (we && wdata[2]) ovf <= 1'b0;
                            if (we && wdata[3]) unf <= 1'b0;
                        end else if (we) begin
                            size_tx <= acc_word;
                            if (tx_ok) begin
                                shreg    <= wdata;
                                left     <= acc_word ? 3'd4 : 3'd1;
                                tag_pend <= acc_frame;
                            end else begin
                                ovf <= 1'b1;
                            end
                        end else begin
                            size_rx <= acc_word;
                            if (rx_ok) begin
                                left     <= acc_word ? 3'd4 : 3'd1;
                                asm      <= '0;
                                first_rd <= 1'b1;
                            end else begin
                                unf <= 1'b1;
                            end
                        end
                    end
                end
                ST_PUSH: begin
                    shreg    <= {8'd0, shreg[31:8]};
                    tag_pend <= 1'b0;
                    left     <= left - 3'd1;
                end
                ST_POP: begin
                    if (word_op) asm <= {rx_head[7:0], asm[31:8]};
                    else         asm <= {24'd0, rx_head[7:0]};
                    if (first_rd) tag_seen <= rx_head[8];
                    first_rd <= 1'b0;
                    left     <= left - 3'd1;
                end
                ST_DONE: begin
                end
                default: begin
                end
            endcase
        end
    end
endmodule

// File: rtl/tagged_fifo_port.sv
`timescale 1ns/1ps
module tagged_fifo_port
    import tfp_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_req,
    input  logic               bus_we,
    input  logic [1:0]         bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic               bus_ack,
    output logic [31:0]        bus_rdata,
    input  logic               tx_pop,
    output logic [ENTRY_W-1:0] tx_dout,
    output logic               tx_empty,
    input  logic               rx_push,
    input  logic [ENTRY_W-1:0] rx_din,
    output logic               rx_full
);
    localparam int CW = $clog2(DEPTH) + 1;

    logic [CW-1:0]      tx_count_i, rx_count_i;
    logic               tx_full_i, rx_empty_i;
    logic               tx_push_i, rx_pop_i;
    logic [ENTRY_W-1:0] tx_din_i, rx_head_i;
    logic               ovf_i, unf_i;

    tfp_fifo #(.W(ENTRY_W), .DEPTH(DEPTH)) i_txq (
        .clk(clk), .rst_n(rst_n),
        .push(tx_push_i), .din(tx_din_i),
        .pop(tx_pop), .dout(tx_dout),
        .count(tx_count_i), .full(tx_full_i), .empty(tx_empty)
    );

    tfp_fifo #(.W(ENTRY_W), .DEPTH(DEPTH)) i_rxq (
        .clk(clk), .rst_n(rst_n),
        .push(rx_push), .din(rx_din),
        .pop(rx_pop_i), .dout(rx_head_i),
        .count(rx_count_i), .full(rx_full), .empty(rx_empty_i)
    );

    tfp_ctl #(.DEPTH(DEPTH)) i_ctl (
        .clk(clk), .rst_n(rst_n),
        .req(bus_req), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
        .ack(bus_ack), .rdata(bus_rdata),
        .tx_count(tx_count_i), .tx_full(tx_full_i), .tx_empty(tx_empty),
        .tx_push(tx_push_i), .tx_din(tx_din_i),
        .rx_count(rx_count_i), .rx_full(rx_full), .rx_empty(rx_empty_i),
        .rx_head(rx_head_i), .rx_pop(rx_pop_i),
        .ovf(ovf_i), .unf(unf_i)
    );
endmodule

// File: rtl/tfp_checker.sv
`timescale 1ns/1ps
module tfp_checker
    import tfp_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       req,
    input logic       we,
    input logic [1:0] addr,
    input logic [1:0] clr_bits,
    input logic       ack,
    input logic       push,
    input logic       push_tag,
    input logic       tx_full,
    input logic       pop,
    input logic       rx_empty,
    input logic       ovf,
    input logic       unf
);
    // R3: a tagged entry is only ever the first push of an access
    p_tag_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (push && push_tag) |-> !$past(push));

    // R5: nothing is pushed into a full transmit queue
    p_no_push_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_full |-> !push);

    // R7: nothing is popped from an empty receive queue
    p_no_pop_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_empty |-> !pop);

    // R11: overflow only falls after a clearing status write
    p_ovf_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ovf) |-> $past(req && we && addr == A_STATUS && clr_bits[0]));

    // R11: underflow only falls after a clearing status write
    p_unf_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(unf) |-> $past(req && we && addr == A_STATUS && clr_bits[1]));

    // R13: acknowledge lasts a single cycle
    p_ack_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);
endmodule

bind tagged_fifo_port tfp_checker i_chk (
    .clk(clk), .rst_n(rst_n),
    .req(bus_req), .we(bus_we), .addr(bus_addr), .clr_bits(bus_wdata[3:2]),
    .ack(bus_ack),
    .push(tx_push_i), .push_tag(tx_din_i[8]), .tx_full(tx_full_i),
    .pop(rx_pop_i), .rx_empty(rx_empty_i),
    .ovf(ovf_i), .unf(unf_i)
);

// File: tb/test_tagged_fifo_port.sv
`timescale 1ns/1ps
module test_tagged_fifo_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic        bus_ack;
    logic [31:0] bus_rdata;
    logic        tx_pop = 1'b0;
    logic [8:0]  tx_dout;
    logic        tx_empty;
    logic        rx_push = 1'b0;
    logic [8:0]  rx_din = '0;
    logic        rx_full;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    tagged_fifo_port #(.DEPTH(16)) i_tagged_fifo_port (
        .clk(clk), .rst_n(rst_n),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .tx_pop(tx_pop), .tx_dout(tx_dout), .tx_empty(tx_empty),
        .rx_push(rx_push), .rx_din(rx_din), .rx_full(rx_full)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic access(input bit we, input logic [1:0] a, input logic [31:0] wd,
                          output logic [31:0] rd);
        int n = 0;
        @(negedge clk);
        bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = wd;
        @(negedge clk);
        bus_req = 1'b0;
        while (!bus_ack && n < 20) begin
            @(negedge clk);
            n++;
        end
        rd = bus_rdata;
        check(bus_ack == 1'b1, "R13 ack", {31'd0, bus_ack}, 32'd1);
        @(negedge clk);
        check(bus_ack == 1'b0, "R13 ack single", {31'd0, bus_ack}, 32'd0);
    endtask

    task automatic status(output logic [31:0] s);
        access(1'b0, 2'd3, 32'd0, s);
    endtask

    task automatic line_take(output logic [8:0] v);
        @(negedge clk);
        v = tx_dout;
        tx_pop = 1'b1;
        @(negedge clk);
        tx_pop = 1'b0;
    endtask

    task automatic line_give(input logic [8:0] v);
        @(negedge clk);
        rx_push = 1'b1; rx_din = v;
        @(negedge clk);
        rx_push = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] s;
        check(bus_rdata == 32'd0, "R12 rdata", bus_rdata, 32'd0);
        status(s);
        check(s == 32'h120, "R12 status", s, 32'h120);
    endtask

    task automatic t_data_word();
        logic [31:0] d, s;
        logic [8:0] v;
        logic [8:0] exp [4] = '{9'h0D4, 9'h0C3, 9'h0B2, 9'h0A1};
        access(1'b1, 2'd0, 32'hA1B2C3D4, d);
        for (int i = 0; i < 4; i++) begin
            line_take(v);
            check(v == exp[i], "R1 order/tag", {23'd0, v}, {23'd0, exp[i]});
        end
        check(tx_empty == 1'b1, "R1 count", {31'd0, tx_empty}, 32'd1);
        status(s);
        check(s[0] == 1'b1, "R10 size_tx word", {31'd0, s[0]}, 32'd1);
    endtask

    task automatic t_frame_byte();
        logic [31:0] d, s;
        logic [8:0] v;
        access(1'b1, 2'd1, 32'hFFFFFF5A, d);
        line_take(v);
        check(v == 9'h15A, "R2 tagged byte", {23'd0, v}, 32'h15A);
        check(tx_empty == 1'b1, "R2 one entry", {31'd0, tx_empty}, 32'd1);
        status(s);
        check(s[0] == 1'b0, "R10 size_tx byte", {31'd0, s[0]}, 32'd0);
    endtask

    task automatic t_frame_word();
        logic [31:0] d;
        logic [8:0] v;
        logic [8:0] exp [4] = '{9'h144, 9'h033, 9'h022, 9'h011};
        access(1'b1, 2'd2, 32'h11223344, d);
        for (int i = 0; i < 4; i++) begin
            line_take(v);
            check(v == exp[i], "R3 first-only tag", {23'd0, v}, {23'd0, exp[i]});
        end
    endtask

    task automatic t_overflow();
        logic [31:0] d, s;
        logic [8:0] v;
        for (int i = 0; i < 13; i++) access(1'b1, 2'd1, 32'h40 + i, d);
        access(1'b1, 2'd0, 32'hDEADBEEF, d);
        status(s);
        check(s[2] == 1'b1, "R4 overflow word", {31'd0, s[2]}, 32'd1);
        check(s[0] == 1'b1, "R10 size on refused", {31'd0, s[0]}, 32'd1);
        access(1'b1, 2'd1, 32'h4D, d);
        status(s);
        check(s[2] == 1'b1, "R11 sticky ovf", {31'd0, s[2]}, 32'd1);
        access(1'b1, 2'd3, 32'h4, d);
        status(s);
        check(s[2] == 1'b0, "R11 clear ovf", {31'd0, s[2]}, 32'd0);
        access(1'b1, 2'd1, 32'h4E, d);
        access(1'b1, 2'd1, 32'h4F, d);
        status(s);
        check(s[2] == 1'b0 && s[4] == 1'b1, "R5 full no ovf", s, 32'h10);
        access(1'b1, 2'd1, 32'hEE, d);
        status(s);
        check(s[2] == 1'b1, "R5 overflow byte", {31'd0, s[2]}, 32'd1);
        for (int i = 0; i < 16; i++) begin
            line_take(v);
            check(v == 9'h140 + 9'(i), "R4 contents kept", {23'd0, v}, 32'h140 + i);
        end
        check(tx_empty == 1'b1, "R4 nothing extra", {31'd0, tx_empty}, 32'd1);
        access(1'b1, 2'd3, 32'h4, d);
    endtask

    task automatic t_underflow();
        logic [31:0] d, s;
        line_give(9'h0A1); line_give(9'h0A2); line_give(9'h0A3);
        access(1'b0, 2'd0, 32'd0, d);
        status(s);
        check(s[3] == 1'b1, "R6 underflow word", {31'd0, s[3]}, 32'd1);
        check(s[1] == 1'b1, "R10 size_rx refused", {31'd0, s[1]}, 32'd1);
        access(1'b1, 2'd3, 32'h8, d);
        status(s);
        check(s[3] == 1'b0, "R11 clear unf", {31'd0, s[3]}, 32'd0);
        for (int i = 0; i < 3; i++) begin
            access(1'b0, 2'd1, 32'd0, d);
            check(d == 32'hA1 + i, "R6 bytes kept", d, 32'hA1 + i);
        end
        status(s);
        check(s[3] == 1'b0 && s[8] == 1'b1, "R6 no flag yet", s, 32'h100);
        access(1'b0, 2'd1, 32'd0, d);
        status(s);
        check(s[3] == 1'b1, "R7 underflow byte", {31'd0, s[3]}, 32'd1);
        check(s[1] == 1'b0, "R10 size_rx byte", {31'd0, s[1]}, 32'd0);
        access(1'b1, 2'd3, 32'h8, d);
    endtask

    task automatic t_reads();
        logic [31:0] d, s;
        line_give(9'h1AA); line_give(9'h0BB); line_give(9'h0CC); line_give(9'h0DD);
        access(1'b0, 2'd2, 32'd0, d);
        check(d == 32'hDDCCBBAA, "R8 word assembly", d, 32'hDDCCBBAA);
        status(s);
        check(s[7] == 1'b1, "R9 tag of word", {31'd0, s[7]}, 32'd1);
        check(s[1] == 1'b1, "R10 size_rx word", {31'd0, s[1]}, 32'd1);
        line_give(9'h011); line_give(9'h122); line_give(9'h033); line_give(9'h044);
        access(1'b0, 2'd0, 32'd0, d);
        check(d == 32'h44332211, "R8 word assembly 2", d, 32'h44332211);
        status(s);
        check(s[7] == 1'b0, "R9 tag only first byte", {31'd0, s[7]}, 32'd0);
        line_give(9'h1F0);
        access(1'b0, 2'd1, 32'd0, d);
        check(d == 32'h000000F0, "R8 byte zero-extended", d, 32'hF0);
        status(s);
        check(s[7] == 1'b1, "R9 tag of byte", {31'd0, s[7]}, 32'd1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_data_word();
        t_frame_byte();
        t_frame_word();
        t_overflow();
        t_underflow();
        t_reads();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule